// File: doc/BRIEF.md
# Multi-Domain Tamper Lockdown Sequencer

This block sits between the tamper detector and the domain-clearing logic of a chip. It holds the tamper response that software actually intends. When that response is a lockdown or an interrupt, the block shows the hardware a plain interrupt response instead. When the tamper interrupt then arrives, the sequencer decides what to do from the response it stored itself, not from the one the hardware saw.

For a lockdown, the sequencer clears the secondary domains one after another, in ascending index order. Each domain gets a request and the sequencer waits for its acknowledge; a per-domain watchdog bounds the wait. Only after every secondary domain has been handled does it write the primary-domain trigger, which starts the primary clear. It then stays locked until reset. For an interrupt-only response, no domain is touched and a single interrupt pulse is passed on to software. Tamper inputs that arrive while a sequence runs, or after lockdown, are ignored.

Top module: `lockdown_seq`

## Requirements
- R1: The response word `cfg_resp_i` uses these bits: [0] interrupt, [1] system reset, [2] lockdown, [3] lockdown with tristated I/O, [4] key erase. Among bits [3:0] only the highest set bit is acted upon. Bit [4] is an add-on to that action.
- R2: `hw_resp_o` is combinational. When the winning bit of `cfg_resp_i[3:0]` is bit 3, bit 2 or bit 0, `hw_resp_o` is `{cfg_resp_i[4], 4'b0001}`. In every other case it equals `cfg_resp_i`.
- R3: After reset, `clr_req_o`, `trig_we_o`, `trig_o`, `sw_irq_o`, `busy_o`, `done_o` and `tmo_err_o` are all zero.
- R4: When `tamper_irq_i` is high at a clock edge while idle and the stored response wins with a lockdown bit, the following cycles show `clr_req_o == 1` (domain 0 only) and `busy_o` high. The response word is captured at that edge; later changes to `cfg_resp_i` do not alter the sequence.
- R5: Domains are requested strictly one at a time, in ascending index order. A request stays high until the cycle after its acknowledge is seen, or for `TMO_CYC` cycles. The next domain's request starts in the very next cycle.
- R6: If a domain does not acknowledge within `TMO_CYC` request cycles, its bit in `tmo_err_o` is set and stays set until reset. The sequence still goes on to the next domain and to the trigger.
- R7: After the last domain completes, `trig_we_o` is high for exactly one cycle. In that cycle `trig_o` holds the winning lockdown bit (bit 3 or bit 2) plus the captured erase bit [4]; all other bits are 0. No trigger is written before every domain has completed.
- R8: After the trigger, `done_o` is high and `busy_o` is low until reset. In that state no request, trigger or software interrupt is produced, even when a tamper interrupt arrives.
- R9: When the winning bit is bit 0, a tamper interrupt gives exactly one cycle of `sw_irq_o` (with `busy_o` high) in the cycle after the edge. No domain request and no trigger occur, and the block returns to idle, ready for the next interrupt.
- R10: When the winning bit is bit 1, or `cfg_resp_i[3:0]` is zero, a tamper interrupt causes no request, trigger or software interrupt, and `busy_o` stays low.
- R11: Tamper interrupts that arrive while a clearing sequence is running neither restart it nor change its order or its trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_resp_i | input | 5 | Intended tamper response word |
| hw_resp_o | output | 5 | Response word presented to the hardware tamper logic |
| tamper_irq_i | input | 1 | Tamper interrupt, sampled while idle |
| clr_req_o | output | N_DOM | Per-domain clear request |
| clr_ack_i | input | N_DOM | Per-domain clear acknowledge |
| trig_o | output | 5 | Primary trigger value, nonzero only while written |
| trig_we_o | output | 1 | Primary trigger write strobe |
| sw_irq_o | output | 1 | Interrupt passed to software for an interrupt-only response |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | Lockdown trigger issued; held until reset |
| tmo_err_o | output | N_DOM | Sticky per-domain acknowledge timeout flags |

## Verification
The response-word mapping is swept over all 32 codes. This separates lockdown, interrupt-only, reset-winning and empty words, and shows whether the erase bit is carried through. Lockdown runs use different per-domain acknowledge delays: all prompt acks, one missing ack in the middle, and a missing ack on the last domain. These show whether ordering is kept, whether the timeout flags the right domain, and whether the trigger still comes after a timeout. Both lockdown variants, alone and together with other bits, show which bit wins in the trigger. Interrupt-only, reset and empty words, plus tampers arriving mid-sequence, after lockdown and with a changed word, show which stimulus is ignored.

// File: rtl/lockdown_seq.sv
module lockdown_seq #(
  parameter int N_DOM   = 4,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cfg_resp_i,
  output logic [4:0]       hw_resp_o,
  input  logic             tamper_irq_i,
  output logic [N_DOM-1:0] clr_req_o,
  input  logic [N_DOM-1:0] clr_ack_i,
  output logic [4:0]       trig_o,
  output logic             trig_we_o,
  output logic             sw_irq_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [N_DOM-1:0] tmo_err_o
);
  localparam int IW = (N_DOM > 1) ? $clog2(N_DOM) : 1;
  localparam int CW = $clog2(TMO_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_TRIG, S_LOCK, S_SWI} st_t;

  st_t             st;
  logic [IW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [4:0]      trig_q;
  logic [N_DOM-1:0] err_q;

  logic is_lock, is_irq, ack_hit, tmo_hit, last_dom, step;

  assign is_lock  = cfg_resp_i[3] | cfg_resp_i[2];
  assign is_irq   = ~cfg_resp_i[3] & ~cfg_resp_i[2] & ~cfg_resp_i[1] & cfg_resp_i[0];
  assign hw_resp_o = (is_lock | is_irq) ? {cfg_resp_i[4], 4'b0001} : cfg_resp_i;

  assign ack_hit  = clr_ack_i[idx];
  assign tmo_hit  = (cnt == CW'(TMO_CYC - 1));
  assign last_dom = (idx == IW'(N_DOM - 1));
  assign step     = ack_hit | tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      cnt    <= '0;
      trig_q <= '0;
      err_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (tamper_irq_i) begin
          if (is_lock) begin
            st     <= S_CLR;
            idx    <= '0;
            cnt    <= '0;
            trig_q <= {cfg_resp_i[4], cfg_resp_i[3], cfg_resp_i[2] & ~cfg_resp_i[3], 2'b00};
          end else if (is_irq) begin
            st <= S_SWI;
          end
        end
        S_CLR: begin
          if (step) begin
            cnt <= '0;
            if (!ack_hit) err_q <= err_q | (N_DOM'(1) << idx);
            if (last_dom) st <= S_TRIG;
            else          idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TRIG:  st <= S_LOCK;
        S_SWI:   st <= S_IDLE;
        default: st <= S_LOCK;
      endcase
    end
  end

  assign clr_req_o = (st == S_CLR) ? (N_DOM'(1) << idx) : '0;
  assign trig_we_o = (st == S_TRIG);
  assign trig_o    = trig_we_o ? trig_q : 5'b0;
  assign sw_irq_o  = (st == S_SWI);
  assign busy_o    = (st == S_CLR) || (st == S_TRIG) || (st == S_SWI);
  assign done_o    = (st == S_LOCK);
  assign tmo_err_o = err_q;

  // R2
  hw_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_resp_o[3:2] == 2'b00 || (!cfg_resp_i[3] && !cfg_resp_i[2]));

  // R5
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_req_o));

  // R7
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we_o |=> !trig_we_o && done_o);

  // R7
  trig_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_we_o |-> $onehot(trig_o[3:2]) && trig_o[1:0] == 2'b00);

  // R8
  locked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o && clr_req_o == '0 && !sw_irq_o && !busy_o);

  // R9
  swirq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_irq_o |-> clr_req_o == '0 && !trig_we_o);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmo_err_o & $past(tmo_err_o)) == $past(tmo_err_o)));
endmodule

// File: tb/lockdown_seq_test.sv
module lockdown_seq_test;
  localparam int ND  = 4;
  localparam int TMO = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    cfg_resp_i = '0;
  logic [4:0]    hw_resp_o;
  logic          tamper_irq_i = 1'b0;
  logic [ND-1:0] clr_req_o;
  logic [ND-1:0] clr_ack_i = '0;
  logic [4:0]    trig_o;
  logic          trig_we_o, sw_irq_o, busy_o, done_o;
  logic [ND-1:0] tmo_err_o;

  lockdown_seq #(.N_DOM(ND), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_resp_i(cfg_resp_i), .hw_resp_o(hw_resp_o),
    .tamper_irq_i(tamper_irq_i), .clr_req_o(clr_req_o), .clr_ack_i(clr_ack_i),
    .trig_o(trig_o), .trig_we_o(trig_we_o), .sw_irq_o(sw_irq_o),
    .busy_o(busy_o), .done_o(done_o), .tmo_err_o(tmo_err_o));

  always #4 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  int exp_q[$];
  int dly[ND];
  int rc[ND];
  bit finished = 0;

  // event codes: kind*256 + data; 1 req, 2 timeout, 3 trigger, 4 software irq
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // domain responders: ack one cycle after dly[i] request cycles; 0 = never
  always @(negedge clk) begin
    for (int i = 0; i < ND; i++) begin
      if (!rst_n || !clr_req_o[i]) begin
        rc[i] = 0;
        clr_ack_i[i] = 1'b0;
      end else begin
        rc[i] = rc[i] + 1;
        clr_ack_i[i] = (dly[i] != 0) && (rc[i] == dly[i]);
      end
    end
  end

  // monitor
  logic [ND-1:0] p_req = '0, p_err = '0;
  task automatic got(input int ev);
    int e;
    if (exp_q.size() == 0) begin
      chk(0, "R5/R7/R8/R9/R10 unexpected event", ev, 0);
    end else begin
      e = exp_q.pop_front();
      chk(ev == e, "R5/R6/R7 event order", ev, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < ND; i++)
        if (tmo_err_o[i] && !p_err[i]) got(2*256 + i);
      for (int i = 0; i < ND; i++)
        if (clr_req_o[i] && !p_req[i]) got(1*256 + i);
      if (trig_we_o) got(3*256 + trig_o);
      if (sw_irq_o) got(4*256);
    end
    p_req = rst_n ? clr_req_o : '0;
    p_err = rst_n ? tmo_err_o : '0;
  end

  function automatic logic [4:0] exp_hw(input logic [4:0] c);
    if (c[3] || c[2]) return {c[4], 4'b0001};
    if (c[1]) return c;
    if (c[0]) return {c[4], 4'b0001};
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tamper_irq_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic tamper();
    @(negedge clk); tamper_irq_i = 1'b1;
    @(negedge clk); tamper_irq_i = 1'b0;
  endtask

  task automatic push_lock(input logic [4:0] c);
    logic [4:0] t;
    exp_q.push_back(1*256);
    for (int i = 0; i < ND; i++) begin
      if (dly[i] == 0 || dly[i] > TMO) exp_q.push_back(2*256 + i);
      if (i < ND - 1) exp_q.push_back(1*256 + i + 1);
    end
    t = {c[4], c[3], c[2] & ~c[3], 2'b00};
    exp_q.push_back(3*256 + t);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && !done_o; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) dly[i] = 1;
    do_reset();
    @(negedge clk);
    // R3 reset state
    chk(clr_req_o == 0 && !trig_we_o && trig_o == 0 && !sw_irq_o && !busy_o &&
        !done_o && tmo_err_o == 0, "R3 reset outputs", {busy_o, done_o, clr_req_o}, 0);

    // R1 R2 mapping sweep
    for (int c = 0; c < 32; c++) begin
      cfg_resp_i = 5'(c);
      #1;
      chk(hw_resp_o == exp_hw(5'(c)), "R1/R2 hw response", hw_resp_o, exp_hw(5'(c)));
    end

    // R4 R5 R7 R8: plain lockdown, prompt acks
    do_reset();
    dly = '{1, 2, 3, 4};
    cfg_resp_i = 5'b00100;
    push_lock(cfg_resp_i);
    tamper();
    chk(clr_req_o == 4'b0001 && busy_o, "R4 first request", clr_req_o, 1);
    wait_done();
    chk(done_o && !busy_o && tmo_err_o == 0, "R8 locked state", {done_o, busy_o, tmo_err_o}, 6'h20);
    chk(exp_q.size() == 0, "R7 trigger issued", exp_q.size(), 0);

    // R6 R11 R4: timeout on domain 1, extra tamper, word changed mid-run
    do_reset();
    dly = '{2, 0, 1, 3};
    cfg_resp_i = 5'b11001;
    push_lock(cfg_resp_i);
    tamper();
    repeat (3) @(negedge clk);
    cfg_resp_i = 5'b00001;
    tamper();   // R11 ignored while busy
    wait_done();
    chk(tmo_err_o == 4'b0010, "R6 timeout flag", tmo_err_o, 4'b0010);
    chk(exp_q.size() == 0, "R11/R4 sequence intact", exp_q.size(), 0);

    // R1 R7: both lockdown bits, last domain times out
    do_reset();
    dly = '{1, 1, 1, 0};
    cfg_resp_i = 5'b01110;
    push_lock(cfg_resp_i);
    tamper();
    wait_done();
    chk(tmo_err_o == 4'b1000 && done_o, "R6/R7 late timeout", tmo_err_o, 4'b1000);
    chk(exp_q.size() == 0, "R1 highest bit wins", exp_q.size(), 0);

    // R8: tamper after lockdown ignored
    cfg_resp_i = 5'b00100;
    tamper();
    repeat (20) @(negedge clk);
    chk(done_o && clr_req_o == 0 && !busy_o, "R8 stays locked", {done_o, busy_o}, 2);

    // R9: interrupt-only, twice
    do_reset();
    cfg_resp_i = 5'b10001;
    exp_q.push_back(4*256);
    tamper();
    chk(sw_irq_o && busy_o && clr_req_o == 0, "R9 sw irq pulse", {sw_irq_o, busy_o}, 3);
    @(negedge clk);
    chk(!sw_irq_o && !busy_o && !done_o, "R9 back to idle", {sw_irq_o, busy_o}, 0);
    exp_q.push_back(4*256);
    tamper();
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0 && !done_o, "R9 second interrupt", exp_q.size(), 0);

    // R10: reset-winning and empty words
    cfg_resp_i = 5'b00011;
    tamper();
    chk(!busy_o, "R10 reset word no action", busy_o, 0);
    repeat (10) @(negedge clk);
    cfg_resp_i = 5'b10000;
    tamper();
    chk(!busy_o, "R10 empty word no action", busy_o, 0);
    repeat (10) @(negedge clk);
    chk(!done_o && clr_req_o == 0, "R10 idle", {done_o, clr_req_o}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule